// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits between a data converter's sample path and its output bus. When a 4-bit mode code selects a test pattern, it puts a generated 12-bit word on the bus each sample clock in place of the converted sample, and it raises a flag that marks the word as test data. When the code selects no pattern, it passes the converter's sample through. The choices are fixed levels, alternating words, a walking one, two pseudo-random sequences and two words loaded by register writes.

A configuration of the block is the mode code together with the 2-bit user sequencing field. Each time that configuration changes, the pattern position restarts, so every alternating or walking pattern begins from its first word. The two pseudo-random generators run freely on every clock. Each one has its own synchronous seed control, so a receiver can re-align to it without disturbing the other generator.

Top module: `adc_test_pattern_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `word_out` becomes 0x000 and `test_active` becomes 0. Both generator states reload to all ones.
- R2: The mode codes 0000, 1101, 1110 and 1111 select no pattern. The next `word_out` is then the `sample_in` from the same edge and `test_active` is 0. All other codes set `test_active` to 1.
- R3: Code 0001 outputs 0x800, code 0010 outputs 0xFFF and code 0011 outputs 0x000 on every sample.
- R4: Code 0100 outputs 0xAAA at pattern position 0 and 0x555 at position 1, and keeps alternating after that.
- R5: The alternating codes run on even and odd positions as follows. Code 0111 gives 0xFFF on even positions and 0x000 on odd ones. Code 1001 gives 0x001 on even positions and 0x000 on odd ones. Code 1100 gives 0x333 on even positions and 0xCCC on odd ones.
- R6: Code 1010 outputs the sync word 0x03F, which has the low six bits set.
- R7: Code 1011 outputs a single 1 at bit (position mod 12). It starts at bit 0 and wraps from bit 11 back to bit 0.
- R8: Code 0110 outputs the 9-bit short generator state, zero-extended. The state shifts left once per clock and takes in bit8 XOR bit4 (x^9+x^5+1).
- R9: Code 0101 outputs bits 22..11 of the 23-bit long generator state. The state shifts left once per clock and takes in bit22 XOR bit17 (x^23+x^18+1).
- R10: When `pn_short_rst` is high at an edge, the short state becomes all ones. When `pn_long_rst` is high at an edge, the long state becomes all ones. Neither control affects the other generator.
- R11: Code 1000 plays the user words. With `user_seq`=00 it outputs `user_pat_a` on every sample. With `user_seq`=01 it outputs `user_pat_a` on even positions and `user_pat_b` on odd positions.
- R12: With code 1000, `user_seq`=10 outputs `user_pat_a` once and then 0x000. `user_seq`=11 outputs `user_pat_a` and then `user_pat_b`, followed by 0x000. In both cases the zeros hold until the configuration changes.
- R13: The pattern position is 0 in the first sample after any change of {`mode_code`, `user_seq`}, and it advances by one each clock. Every output is registered, one clock after the inputs it depends on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_code | input | 4 | Test pattern select |
| user_seq | input | 2 | User pattern play sequence |
| pn_short_rst | input | 1 | Reseed the 9-bit generator |
| pn_long_rst | input | 1 | Reseed the 23-bit generator |
| user_pat_a | input | 12 | First user word |
| user_pat_b | input | 12 | Second user word |
| sample_in | input | 12 | Normal converter sample |
| word_out | output | 12 | Output bus word |
| test_active | output | 1 | Word is test data |

## Verification
Two events can land in the same cycle. The first case is a generator reseed that arrives with the switch into that generator's mode. The bench provokes it by raising `pn_short_rst` on the very edge where the code changes to 0110, and it expects the first word to come from the free-running state, with the seeded value of 0x1FF showing one sample later. The second case is a configuration rewrite that arrives just as a once-sequence has run out. The bench changes `user_seq` from 11 to 10 on the cycle after the zeros begin, and it expects `user_pat_a` to reappear at once, since the restart takes priority over the held zeros.

// File: rtl/atpg_pkg.sv
package atpg_pkg;
  localparam int WORD_W  = 12;
  localparam int SEQ_W   = 2;
  localparam int MODE_W  = 4;
  localparam int PNS_LEN = 9;
  localparam int PNS_TAP = 5;
  localparam int PNL_LEN = 23;
  localparam int PNL_TAP = 18;

  localparam logic [MODE_W-1:0] M_MID  = 4'd1;
  localparam logic [MODE_W-1:0] M_PFS  = 4'd2;
  localparam logic [MODE_W-1:0] M_NFS  = 4'd3;
  localparam logic [MODE_W-1:0] M_CHK  = 4'd4;
  localparam logic [MODE_W-1:0] M_PNL  = 4'd5;
  localparam logic [MODE_W-1:0] M_PNS  = 4'd6;
  localparam logic [MODE_W-1:0] M_WTOG = 4'd7;
  localparam logic [MODE_W-1:0] M_USER = 4'd8;
  localparam logic [MODE_W-1:0] M_BTOG = 4'd9;
  localparam logic [MODE_W-1:0] M_SYNC = 4'd10;
  localparam logic [MODE_W-1:0] M_WALK = 4'd11;
  localparam logic [MODE_W-1:0] M_MIX  = 4'd12;

  function automatic logic is_test_mode(input logic [MODE_W-1:0] m);
    return (m >= M_MID) && (m <= M_MIX);
  endfunction

  // ph=0: odd bits set; ph=1: even bits set
  function automatic logic [WORD_W-1:0] checker_word(input logic ph);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = ((i % 2) == 1) ^ ph;
    return r;
  endfunction

  // pairs of ones and zeros, inverted on odd phase
  function automatic logic [WORD_W-1:0] mixed_word(input logic ph);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = ((i % 4) < 2) ^ ph;
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] sync_word();
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = (i < WORD_W / 2);
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] walk_word(input int unsigned idx);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = (i == idx);
    return r;
  endfunction
endpackage

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
  parameter int LEN = 9,
  parameter int TAP = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           seed_i,
  output logic [LEN-1:0] state_o
);
  logic [LEN-1:0] state_q;
  logic           fb;

  assign fb      = state_q[LEN-1] ^ state_q[TAP-1];
  assign state_o = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n || seed_i) state_q <= '1;
    else                  state_q <= {state_q[LEN-2:0], fb};
  end

  assert_seed_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seed_i |=> (state_o == '1));

  assert_never_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != '0);

  assert_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_i |=> (state_o[LEN-1:1] == $past(state_o[LEN-2:0])));
endmodule

// File: rtl/pattern_seq.sv
module pattern_seq #(
  parameter int CFG_W = 6,
  parameter int POS_N = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CFG_W-1:0]         cfg_i,
  output logic [$clog2(POS_N)-1:0] pos_o,
  output logic [1:0]               seen_o,
  output logic                     restart_o
);
  localparam int POS_W = $clog2(POS_N);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(POS_N - 1);

  logic [CFG_W-1:0] cfg_q;
  logic [POS_W-1:0] pos_q;
  logic [1:0]       seen_q;

  assign restart_o = (cfg_i != cfg_q);
  assign pos_o     = restart_o ? '0 : pos_q;
  assign seen_o    = restart_o ? 2'd0 : seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      pos_q  <= '0;
      seen_q <= 2'd0;
    end else begin
      cfg_q  <= cfg_i;
      pos_q  <= (pos_o == POS_LAST) ? '0 : pos_o + 1'b1;
      seen_q <= (seen_o == 2'd2) ? 2'd2 : seen_o + 2'd1;
    end
  end

  assert_restart_pos_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_o && $stable(cfg_i)) |-> (pos_o == '0));

  assert_pos_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pos_o < POS_W'(POS_N));

  assert_seen_sat_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_o == 2'd2 && !$changed(cfg_i)) |=> (seen_o == 2'd2 || restart_o));
endmodule

// File: rtl/adc_test_pattern_gen.sv
module adc_test_pattern_gen
  import atpg_pkg::*;
#(
  parameter int POS_N = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_code,
  input  logic [SEQ_W-1:0]  user_seq,
  input  logic              pn_short_rst,
  input  logic              pn_long_rst,
  input  logic [WORD_W-1:0] user_pat_a,
  input  logic [WORD_W-1:0] user_pat_b,
  input  logic [WORD_W-1:0] sample_in,
  output logic [WORD_W-1:0] word_out,
  output logic              test_active
);
  localparam int CFG_W = MODE_W + SEQ_W;
  localparam int POS_W = $clog2(POS_N);

  logic [PNS_LEN-1:0] short_state;
  logic [PNL_LEN-1:0] long_state;
  logic [POS_W-1:0]   pos;
  logic [1:0]         seen;
  logic               restart;
  logic               ph;
  logic               sel_test;
  logic [WORD_W-1:0]  user_word;
  logic [WORD_W-1:0]  nxt_word;

  pn_lfsr #(.LEN(PNS_LEN), .TAP(PNS_TAP)) u_pn_short (
    .clk(clk), .rst_n(rst_n), .seed_i(pn_short_rst), .state_o(short_state));

  pn_lfsr #(.LEN(PNL_LEN), .TAP(PNL_TAP)) u_pn_long (
    .clk(clk), .rst_n(rst_n), .seed_i(pn_long_rst), .state_o(long_state));

  pattern_seq #(.CFG_W(CFG_W), .POS_N(POS_N)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_i({mode_code, user_seq}),
    .pos_o(pos), .seen_o(seen), .restart_o(restart));

  assign ph       = pos[0];
  assign sel_test = is_test_mode(mode_code);

  always_comb begin
    case (user_seq)
      2'b00:   user_word = user_pat_a;
      2'b01:   user_word = ph ? user_pat_b : user_pat_a;
      2'b10:   user_word = (seen == 2'd0) ? user_pat_a : '0;
      default: user_word = (seen == 2'd0) ? user_pat_a :
                           (seen == 2'd1) ? user_pat_b : '0;
    endcase
  end

  always_comb begin
    case (mode_code)
      M_MID:   nxt_word = WORD_W'(1) << (WORD_W - 1);
      M_PFS:   nxt_word = '1;
      M_NFS:   nxt_word = '0;
      M_CHK:   nxt_word = checker_word(ph);
      M_PNL:   nxt_word = long_state[PNL_LEN-1 -: WORD_W];
      M_PNS:   nxt_word = WORD_W'(short_state);
      M_WTOG:  nxt_word = ph ? '0 : '1;
      M_USER:  nxt_word = user_word;
      M_BTOG:  nxt_word = WORD_W'(!ph);
      M_SYNC:  nxt_word = sync_word();
      M_WALK:  nxt_word = walk_word(32'(pos));
      M_MIX:   nxt_word = mixed_word(ph);
      default: nxt_word = sample_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_out    <= '0;
      test_active <= 1'b0;
    end else begin
      word_out    <= nxt_word;
      test_active <= sel_test;
    end
  end

  assert_off_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_test |=> (!test_active && word_out == $past(sample_in)));

  assert_walk_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == M_WALK) |=> ($countones(word_out) == 1));

  assert_once_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == M_USER && user_seq[1] && seen == 2'd2) |=> (word_out == '0));

  assert_restart_first_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && mode_code == M_CHK) |=> (word_out == checker_word(1'b0)));
endmodule

// File: tb/adc_test_pattern_gen_bench.sv
module adc_test_pattern_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode_code = 4'd0;
  logic [1:0]  user_seq = 2'd0;
  logic        pn_short_rst = 1'b0;
  logic        pn_long_rst = 1'b0;
  logic [11:0] user_pat_a = 12'h5E1;
  logic [11:0] user_pat_b = 12'h3C7;
  logic [11:0] sample_in = 12'h000;
  logic [11:0] word_out;
  logic        test_active;

  int total = 0;
  int bad = 0;
  string tag = "R1";
  bit primed = 0;
  bit finished = 0;

  int e_w, e_a, pcfg, pos, seen, s9, s23;
  localparam int M23 = (1 << 23) - 1;

  always #4 clk = ~clk;

  adc_test_pattern_gen u_adc_test_pattern_gen (
    .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .user_seq(user_seq),
    .pn_short_rst(pn_short_rst), .pn_long_rst(pn_long_rst),
    .user_pat_a(user_pat_a), .user_pat_b(user_pat_b), .sample_in(sample_in),
    .word_out(word_out), .test_active(test_active));

  // behavioural reference, evaluated on the inputs seen at each edge
  always @(posedge clk) begin
    int cfg, p, sn;
    bit chg;
    if (!rst_n) begin
      e_w = 0; e_a = 0; pcfg = 0; pos = 0; seen = 0; s9 = 511; s23 = M23;
    end else begin
      cfg = int'(mode_code) * 4 + int'(user_seq);
      chg = (cfg != pcfg);
      p  = chg ? 0 : pos;
      sn = chg ? 0 : seen;
      e_a = 1;
      case (mode_code)
        4'd1:  e_w = 'h800;
        4'd2:  e_w = 'hFFF;
        4'd3:  e_w = 'h000;
        4'd4:  e_w = (p % 2) ? 'h555 : 'hAAA;
        4'd5:  e_w = (s23 >> 11) & 'hFFF;
        4'd6:  e_w = s9;
        4'd7:  e_w = (p % 2) ? 'h000 : 'hFFF;
        4'd8: begin
          case (user_seq)
            2'd0: e_w = user_pat_a;
            2'd1: e_w = (p % 2) ? user_pat_b : user_pat_a;
            2'd2: e_w = (sn == 0) ? user_pat_a : 0;
            default: e_w = (sn == 0) ? user_pat_a : (sn == 1) ? user_pat_b : 0;
          endcase
        end
        4'd9:  e_w = (p % 2) ? 'h000 : 'h001;
        4'd10: e_w = 'h03F;
        4'd11: e_w = 1 << p;
        4'd12: e_w = (p % 2) ? 'hCCC : 'h333;
        default: begin e_w = sample_in; e_a = 0; end
      endcase
      pos  = (p + 1) % 12;
      seen = (sn < 2) ? sn + 1 : 2;
      pcfg = cfg;
      s9  = pn_short_rst ? 511 : (((s9 << 1) & 511) | (((s9 >> 8) ^ (s9 >> 4)) & 1));
      s23 = pn_long_rst ? M23 : (((s23 << 1) & M23) | (((s23 >> 22) ^ (s23 >> 17)) & 1));
    end
    primed = 1;
  end

  always @(negedge clk) begin
    if (primed && !finished) begin
      total++;
      if (int'(word_out) != e_w || int'(test_active) != e_a) begin
        bad++;
        $display("FAIL %s word=%h act=%0d expected word=%h act=%0d",
                 tag, word_out, test_active, e_w[11:0], e_a);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      sample_in = 12'($urandom);
    end
  endtask

  task automatic run(input logic [3:0] m, input logic [1:0] us, input int n,
                     input string t);
    @(negedge clk); #1;
    tag = t; mode_code = m; user_seq = us; sample_in = 12'($urandom);
    step(n);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);                                  // R1 reset state compared each cycle
    @(negedge clk); #1; rst_n = 1'b1;
    run(4'd0, 2'd0, 6, "R2");
    run(4'd13, 2'd0, 3, "R2"); run(4'd14, 2'd0, 3, "R2"); run(4'd15, 2'd0, 3, "R2");
    run(4'd1, 2'd0, 3, "R3"); run(4'd2, 2'd0, 3, "R3"); run(4'd3, 2'd0, 3, "R3");
    run(4'd4, 2'd0, 6, "R4");
    run(4'd7, 2'd0, 5, "R5"); run(4'd9, 2'd0, 5, "R5"); run(4'd12, 2'd0, 5, "R5");
    run(4'd10, 2'd0, 3, "R6");
    run(4'd11, 2'd0, 30, "R7");
    run(4'd6, 2'd0, 40, "R8");
    run(4'd5, 2'd0, 40, "R9");
    // R10: reseed short while long keeps running, and the reverse
    run(4'd0, 2'd0, 2, "R10");
    @(negedge clk); #1; tag = "R10"; mode_code = 4'd6; pn_short_rst = 1'b1; pn_long_rst = 1'b0;
    step(1); pn_short_rst = 1'b0;
    step(12);
    pn_long_rst = 1'b1; step(2); pn_long_rst = 1'b0; step(6);
    run(4'd5, 2'd0, 6, "R10");
    pn_short_rst = 1'b1; step(1); pn_short_rst = 1'b0; step(6);
    // R11 and R12
    run(4'd8, 2'd0, 4, "R11"); run(4'd8, 2'd1, 6, "R11");
    user_pat_a = 12'hABC; user_pat_b = 12'h123; step(4);
    run(4'd8, 2'd2, 6, "R12"); run(4'd8, 2'd3, 3, "R12");
    run(4'd8, 2'd2, 4, "R12");
    run(4'd0, 2'd2, 2, "R13"); run(4'd8, 2'd3, 6, "R13");
    run(4'd4, 2'd0, 3, "R13"); run(4'd4, 2'd1, 3, "R13");
    @(negedge clk); #1; tag = "R1"; rst_n = 1'b0; step(3);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule